// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the host-facing register file of a serial port. A host reaches six word-sized registers through a simple single-cycle bus. The registers hold the most recent received character, the character to send, a status word, a control word, a baud divisor and an end-of-packet character. Each register keeps only the bits that are valid for it, and any bit above that width reads as zero. The block does not contain the bit shifter or the baud generator. It stores the divisor, offers a valid/ready handshake that gives the pending transmit character to a shifter, and accepts a one-cycle strobe that delivers a received character.

Two flags in the status word track the data path. The transmit-ready flag drops when the host writes a character and rises again once the shifter has taken it. The receive-ready flag rises when a character is accepted and drops when the host reads the receive register. An interrupt line is raised whenever a flag is set and its enable bit in the control word is also set.

Top module: `sport_csr`

## Requirements
- R1: After reset the receive, transmit, control, divisor and end-of-packet registers are zero. Status is 0x40, which means transmit-ready (bit 6) is set and receive-ready (bit 7) is clear. tx_valid and irq are low.
- R2: The word offsets are receive 0, transmit 1, status 2, control 3, divisor 4 and end-of-packet 5. Their valid widths are 9, 9, 13, 13, 16 and 9 bits. A read with bus_re presents the masked value, zero-extended, on bus_rdata from the next clock edge. bus_rdata holds its value when no read is made.
- R3: Offsets 6 and above read as zero, and writes to them change no register.
- R4: Host writes to the receive register leave it unchanged.
- R5: A write to offset 1 loads the character, clears status bit 6, and raises tx_valid from the next cycle, with tx_byte equal to the written value.
- R6: In a cycle where tx_valid and tx_ready are both high, the character is handed over. tx_valid then falls and status bit 6 is set. If a write to offset 1 happens in the same cycle, the write wins: tx_valid stays high and bit 6 stays clear.
- R7: A rx_strobe while no received character is pending stores rx_byte and sets status bit 7. A strobe while a character is pending is dropped and the stored character is kept.
- R8: A read of offset 0 clears status bit 7 and the pending state. A strobe in the same cycle is dropped.
- R9: irq is high exactly when (control bit 6 AND status bit 6) OR (control bit 7 AND status bit 7), taken from the current register values.
- R10: A host write to offset 2 replaces all 13 status bits. It does not change the pending state. A same-cycle transmit or receive event still sets or clears its own flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Word offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W (32) | Registered read data |
| tx_valid | output | 1 | A transmit character is pending |
| tx_ready | input | 1 | The shifter takes the pending character |
| tx_byte | output | CHAR_W (9) | Pending transmit character |
| rx_strobe | input | 1 | A received character is present this cycle |
| rx_byte | input | CHAR_W (9) | Received character |
| irq | output | 1 | Enabled ready condition present |

## Verification
The bench builds the block with its default parameters: a 4-bit word address, a 32-bit data bus and 9-bit characters. The 4-bit address makes ten undecoded offsets reachable for the R3 checks. The wide data bus leaves bits above every register mask, so the bench can see that they read as zero. The 9-bit characters exercise the top data bit on both the transmit and receive paths. The directed phases cover the same-cycle collisions: a transmit write during a hand-off, a receive strobe during a read, and a status write during a flag event. A random phase then mixes all the inputs.

// File: rtl/sport_csr_pkg.sv
package sport_csr_pkg;
  localparam int OFF_RX  = 0;
  localparam int OFF_TX  = 1;
  localparam int OFF_ST  = 2;
  localparam int OFF_CTL = 3;
  localparam int OFF_DIV = 4;
  localparam int OFF_EOP = 5;
  localparam int NREG    = 6;

  localparam int BIT_TRDY = 6;
  localparam int BIT_RRDY = 7;

  // interrupt condition from the two flag/enable pairs
  function automatic logic ready_irq(input logic st_t, input logic st_r,
                                     input logic en_t, input logic en_r);
    return (st_t & en_t) | (st_r & en_r);
  endfunction

  // next value of a flag: a clearing event beats a setting event
  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction
endpackage

// File: rtl/sport_decode.sv
module sport_decode #(
  parameter int ADDR_W = 4,
  parameter int NSEL   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic [NSEL-1:0]   wr_sel,
  output logic [NSEL-1:0]   rd_sel
);
  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    logic hit;
    assign hit       = (int'(addr) == i);
    assign wr_sel[i] = we & hit;
    assign rd_sel[i] = re & hit;
  end
endmodule

// File: rtl/sport_tx_side.sv
module sport_tx_side #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              tx_ready,
  output logic              pend,
  output logic              done,
  output logic [CHAR_W-1:0] data_q
);
  assign done = pend & tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) begin
        pend   <= 1'b1;
        data_q <= wchar;
      end else if (done) begin
        pend   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sport_rx_side.sv
module sport_rx_side #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CHAR_W-1:0] rchar,
  input  logic              drain,
  output logic              pend,
  output logic              take,
  output logic [CHAR_W-1:0] data_q
);
  assign take = strobe & ~pend & ~drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      data_q <= '0;
    end else begin
      pend <= sport_csr_pkg::flag_next(pend, drain, take);
      if (take) data_q <= rchar;
    end
  end
endmodule

// File: rtl/sport_csr.sv
module sport_csr #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 9,
  parameter int FLAG_W = 13,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_byte,
  input  logic              rx_strobe,
  input  logic [CHAR_W-1:0] rx_byte,
  output logic              irq
);
  import sport_csr_pkg::*;

  localparam logic [FLAG_W-1:0] ST_RESET = FLAG_W'(1) << BIT_TRDY;

  logic [NREG-1:0]   wr_sel, rd_sel;
  logic              tx_load, tx_done, tx_pend;
  logic              rx_take, rx_drain, rx_pend;
  logic [CHAR_W-1:0] tx_q, rx_q;
  logic [FLAG_W-1:0] st_q, st_d, ctl_q;
  logic [DIV_W-1:0]  div_q;
  logic [CHAR_W-1:0] eop_q;
  logic [DATA_W-1:0] rd_val, rdata_q;

  sport_decode #(.ADDR_W(ADDR_W), .NSEL(NREG)) u_dec (
    .addr(bus_addr), .we(bus_we), .re(bus_re), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign tx_load  = wr_sel[OFF_TX];
  assign rx_drain = rd_sel[OFF_RX];

  sport_tx_side #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .wchar(bus_wdata[CHAR_W-1:0]),
    .tx_ready(tx_ready), .pend(tx_pend), .done(tx_done), .data_q(tx_q)
  );

  sport_rx_side #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .rchar(rx_byte),
    .drain(rx_drain), .pend(rx_pend), .take(rx_take), .data_q(rx_q)
  );

  // status: host write first, then hardware flag events on top
  always_comb begin
    st_d = st_q;
    if (wr_sel[OFF_ST]) st_d = bus_wdata[FLAG_W-1:0];
    st_d[BIT_TRDY] = flag_next(st_d[BIT_TRDY], tx_load, tx_done);
    st_d[BIT_RRDY] = flag_next(st_d[BIT_RRDY], rx_drain, rx_take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_RESET;
      ctl_q <= '0;
      div_q <= '0;
      eop_q <= '0;
    end else begin
      st_q <= st_d;
      if (wr_sel[OFF_CTL]) ctl_q <= bus_wdata[FLAG_W-1:0];
      if (wr_sel[OFF_DIV]) div_q <= bus_wdata[DIV_W-1:0];
      if (wr_sel[OFF_EOP]) eop_q <= bus_wdata[CHAR_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_sel[OFF_RX])  rd_val = DATA_W'(rx_q);
    if (rd_sel[OFF_TX])  rd_val = DATA_W'(tx_q);
    if (rd_sel[OFF_ST])  rd_val = DATA_W'(st_q);
    if (rd_sel[OFF_CTL]) rd_val = DATA_W'(ctl_q);
    if (rd_sel[OFF_DIV]) rd_val = DATA_W'(div_q);
    if (rd_sel[OFF_EOP]) rd_val = DATA_W'(eop_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = tx_pend;
  assign tx_byte   = tx_q;
  assign irq       = ready_irq(st_q[BIT_TRDY], st_q[BIT_RRDY],
                               ctl_q[BIT_TRDY], ctl_q[BIT_RRDY]);
endmodule

// File: rtl/sport_csr_chk.sv
module sport_csr_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 9,
  parameter int FLAG_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              irq,
  input logic              tx_load,
  input logic              tx_done,
  input logic              rx_take,
  input logic              rx_drain,
  input logic              rx_pend,
  input logic [CHAR_W-1:0] rx_q,
  input logic [FLAG_W-1:0] ctl_q
);
  // R5
  tx_load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_valid);
  // R6
  tx_done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_load) |=> !tx_valid);
  // R7
  rx_take_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> rx_pend);
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_take |=> $stable(rx_q));
  // R8
  rx_drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drain |=> !rx_pend);
  // R8
  rx_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_take && rx_drain));
  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && int'(bus_addr) >= 6) |=> (bus_rdata == '0));
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[6] && !ctl_q[7]) |-> !irq);
endmodule

bind sport_csr sport_csr_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .irq(irq), .tx_load(tx_load),
  .tx_done(tx_done), .rx_take(rx_take), .rx_drain(rx_drain), .rx_pend(rx_pend),
  .rx_q(rx_q), .ctl_q(ctl_q)
);

// File: tb/sport_csr_test.sv
module sport_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [8:0]  tx_byte;
  logic        rx_strobe = 1'b0;
  logic [8:0]  rx_byte = '0;
  logic        irq;

  int    checks = 0, fails = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // reference state
  logic [8:0]  m_rx, m_tx, m_eop;
  logic [12:0] m_st, m_ctl;
  logic [15:0] m_div;
  logic [31:0] m_rd;
  bit          m_txp, m_rxp;
  int          a;
  bit          ld, dn, dr, tk;
  logic [12:0] ns;

  always #5 clk = ~clk;

  sport_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_eop = 0; m_ctl = 0; m_div = 0; m_rd = 0;
      m_st = 13'h040; m_txp = 0; m_rxp = 0;
    end else begin
      a = int'(bus_addr);
      if (bus_re) begin
        case (a)
          0: m_rd = {23'd0, m_rx};
          1: m_rd = {23'd0, m_tx};
          2: m_rd = {19'd0, m_st};
          3: m_rd = {19'd0, m_ctl};
          4: m_rd = {16'd0, m_div};
          5: m_rd = {23'd0, m_eop};
          default: m_rd = 0;
        endcase
      end
      ld = bus_we && a == 1;
      dn = m_txp && tx_ready;
      dr = bus_re && a == 0;
      tk = rx_strobe && !m_rxp && !dr;
      ns = m_st;
      if (bus_we && a == 2) ns = bus_wdata[12:0];
      if (ld) ns[6] = 0; else if (dn) ns[6] = 1;
      if (dr) ns[7] = 0; else if (tk) ns[7] = 1;
      m_st = ns;
      if (bus_we && a == 3) m_ctl = bus_wdata[12:0];
      if (bus_we && a == 4) m_div = bus_wdata[15:0];
      if (bus_we && a == 5) m_eop = bus_wdata[8:0];
      if (ld) begin m_tx = bus_wdata[8:0]; m_txp = 1; end
      else if (dn) m_txp = 0;
      if (tk) begin m_rx = rx_byte; m_rxp = 1; end
      else if (dr) m_rxp = 0;
    end
  end

  task automatic compare();
    logic exp_irq;
    exp_irq = (m_st[6] & m_ctl[6]) | (m_st[7] & m_ctl[7]);
    checks++;
    if (bus_rdata !== m_rd) begin
      fails++; $display("FAIL %s bus_rdata got %h exp %h", cur_req, bus_rdata, m_rd);
    end
    checks++;
    if (tx_valid !== m_txp) begin
      fails++; $display("FAIL %s tx_valid got %b exp %b", cur_req, tx_valid, m_txp);
    end
    checks++;
    if (tx_byte !== m_tx) begin
      fails++; $display("FAIL %s tx_byte got %h exp %h", cur_req, tx_byte, m_tx);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++; $display("FAIL %s irq got %b exp %b", cur_req, irq, exp_irq);
    end
  endtask

  task automatic step(input bit we, input bit re, input int ad, input logic [31:0] wd,
                      input bit txr, input bit rxs, input logic [8:0] rxb);
    @(negedge clk);
    if (rst_n) compare();
    bus_we = we; bus_re = re; bus_addr = 4'(ad); bus_wdata = wd;
    tx_ready = txr; rx_strobe = rxs; rx_byte = rxb;
  endtask

  task automatic wr(input int ad, input logic [31:0] wd);
    step(1, 0, ad, wd, 0, 0, 0);
  endtask
  task automatic rd(input int ad);
    step(0, 1, ad, 0, 0, 0, 0);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cur_req = "R1";
    idle();
    for (int i = 0; i < 6; i++) rd(i);
    idle();
    // R2 masked read-back of writable registers
    cur_req = "R2";
    for (int i = 2; i < 6; i++) wr(i, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) rd(i);
    wr(3, 32'h0000_1234); wr(4, 32'hABCD_5A5A); wr(5, 32'h0000_0155);
    for (int i = 2; i < 6; i++) rd(i);
    idle(); idle();
    // R3 undecoded offsets
    cur_req = "R3";
    for (int i = 6; i < 16; i++) wr(i, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) rd(i);
    // R4 receive register is read-only
    cur_req = "R4";
    wr(0, 32'h0000_01FF); rd(0); idle();
    // R5 transmit write
    cur_req = "R5";
    wr(2, 32'h0000_0040);
    wr(1, 32'h0000_01A5); idle(); rd(2); idle(); idle();
    // R6 hand-off and collision with a new write
    cur_req = "R6";
    step(0, 0, 0, 0, 1, 0, 0); step(0, 1, 2, 0, 0, 0, 0); idle();
    wr(1, 32'h0000_0011); step(0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 1, 32'h0000_0122, 1, 0, 0); rd(2); idle();
    step(0, 0, 0, 0, 1, 0, 0); rd(2); idle();
    // R7 receive accept and drop while pending
    cur_req = "R7";
    step(0, 0, 0, 0, 0, 1, 9'h1C3); rd(2);
    step(0, 0, 0, 0, 0, 1, 9'h055); idle();
    // R8 read clears, same-cycle strobe dropped
    cur_req = "R8";
    rd(0); rd(2);
    step(0, 1, 0, 0, 0, 1, 9'h0AA); rd(2); rd(0);
    step(0, 0, 0, 0, 0, 1, 9'h101); rd(0); rd(2);
    // R9 interrupt enables
    cur_req = "R9";
    wr(3, 32'h0000_0040); idle(); wr(3, 32'h0000_0080); idle();
    step(0, 0, 0, 0, 0, 1, 9'h033); idle(); rd(0); idle();
    wr(3, 32'h0000_00C0); wr(1, 32'h0000_0002); idle();
    step(0, 0, 0, 0, 1, 0, 0); idle(); wr(3, 0); idle();
    // R10 status write against flag events
    cur_req = "R10";
    wr(2, 32'h0000_1FFF); rd(2); wr(2, 0); rd(2);
    wr(1, 32'h0000_0100); step(1, 0, 2, 32'h0000_0040, 1, 0, 0); rd(2); idle();
    step(1, 0, 2, 32'h0000_0000, 0, 1, 9'h077); rd(2); rd(0); idle();
    step(1, 0, 2, 32'h0000_0080, 0, 1, 9'h011); rd(2); rd(0); idle();
    // mixed traffic
    cur_req = "R2";
    for (int i = 0; i < 400; i++)
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), $urandom_range(0, 15),
           $urandom, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           9'($urandom));
    idle(); idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL %s watchdog got running exp finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule